// File: doc/BRIEF.md
# Pixel-Sync Timing and Power-Down Sequencer

This block is the digital timing core of a serial-output line-sensor digitiser. It runs on the master clock and samples a pixel sync input at every rising edge. From the sync waveform it finds the sampling instant of each pixel and issues a one-cycle sample strobe to a sample-and-hold model. One cycle later it issues a conversion-start pulse. It also keeps a running pixel index.

The master-clock-to-pixel ratio is 12:1 or 16:1, chosen by a static select input. A sync period that is too short is reported through a sequence-restart flag, and so is a sync pulse that covers more than one edge. In both cases sampling resynchronises to the last high edge. If sync is held high long enough, the block enters power-down: it raises a power-down flag and drops the serial-output enable. The first edge that sees sync low brings the block back up.

The reset is asynchronous and active-low, and its release is synchronised inside the block. Because of this, the block comes out of reset two clock edges after `rst_n` rises.

Top module: `pixsync_seq`

## Requirements
- R1: While reset is asserted, and after it is released with sync low, `sample_stb`, `conv_start`, `seq_restart` and `pwr_down` are 0, `dout_oe` is 1 and `pix_idx` is 0.
- R2: The first rising edge at which `pix_sync` is sampled low after one or more high edges is the sampling edge. `sample_stb` is 1 for exactly the one cycle that follows that edge. No other edge produces a strobe.
- R3: `conv_start` is 1 for exactly the one cycle that follows each `sample_stb` cycle, and at no other time.
- R4: `pix_idx` counts samples since reset or since the last power-down, modulo 2^IDX_W. It takes its new value in the same cycle as `sample_stb`, so the first sample after reset shows 1 and the value after 255 is 0.
- R5: With `ratio_sel`=0 (12:1), sync high for 1 edge and low for 11 edges gives a strobe with `seq_restart`=0 on every pixel.
- R6: With `ratio_sel`=1 (16:1), the nominal low run is 15 edges and does not set `seq_restart`. A low run of 11 or 14 edges does set it.
- R7: If the low run before a sync pulse is shorter than the ratio minus one, the strobe for that pulse carries `seq_restart`=1. The first pulse after reset or after power-down is never flagged this way.
- R8: A sync pulse that covers 2 to 63 edges is sampled at the edge after its last high edge, and its strobe carries `seq_restart`=1.
- R9: When the 64th consecutive high edge of sync is seen, `pwr_down` becomes 1 and `dout_oe` becomes 0 in the following cycle, and `pix_idx` is cleared. After 63 high edges `pwr_down` is still 0. No strobe is issued while powered down.
- R10: In power-down, the first edge at which sync is low clears `pwr_down` and sets `dout_oe`, without a sample strobe. The next pulse is treated as the first one after reset.
- R11: The high-run counter saturates: holding sync high for far more than 64 edges keeps `pwr_down` at 1 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; everything acts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 1 | Static ratio select: 0 = 12:1, 1 = 16:1 |
| pix_sync | input | 1 | Pixel sync pulse input |
| sample_stb | output | 1 | One-cycle sample strobe for the sample-and-hold |
| conv_start | output | 1 | One-cycle conversion start, one cycle after the strobe |
| pix_idx | output | IDX_W | Pixel count since reset or power-down |
| seq_restart | output | 1 | Valid with `sample_stb`: early or widened sync seen |
| pwr_down | output | 1 | Power-down state |
| dout_oe | output | 1 | Serial output enable, low in power-down |

## Verification
The main function is exercised with several sync patterns. Nominal single-edge pulses at both ratios must give clean strobes. Low runs one edge short, and much shorter, in each mode separate a correct early-period threshold from an off-by-one. Widened pulses of 3 and 63 edges show that sampling follows the last high edge and that the power-down count does not fire one edge early. A 100-edge hold, followed by a short and then a nominal period, shows saturation, silent wake-up and the reset of the synchronised state. A run of more than 256 pixels covers the wrap of the pixel index.

// File: rtl/pixsync_pkg.sv
package pixsync_pkg;

  typedef enum logic {
    RATIO_12 = 1'b0,
    RATIO_16 = 1'b1
  } ratio_e;

  // Low edges expected between two nominal sync pulses.
  function automatic int unsigned low_span(input int unsigned period);
    return period - 1;
  endfunction

endpackage

// File: rtl/pixsync_rst_sync.sv
module pixsync_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_s = stage_q[1];

endmodule

// File: rtl/pixsync_edge_trk.sv
module pixsync_edge_trk #(
  parameter int unsigned HI_MAX = 64,
  parameter int unsigned LO_MAX = 16,
  parameter int unsigned HI_W   = 7,
  parameter int unsigned LO_W   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_in,
  output logic            rise_e,
  output logic            fall_e,
  output logic            hi_hit,
  output logic [HI_W-1:0] hi_cnt,
  output logic [LO_W-1:0] lo_cnt
);

  logic            sync_q;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;

  always_comb begin
    rise_e = sync_in & ~sync_q;
    fall_e = ~sync_in & sync_q;
    hi_d   = '0;
    lo_d   = '0;
    if (sync_in) begin
      if (!sync_q)                 hi_d = HI_W'(1);
      else if (hi_q == HI_W'(HI_MAX)) hi_d = hi_q;
      else                         hi_d = hi_q + HI_W'(1);
    end else begin
      if (lo_q == LO_W'(LO_MAX))   lo_d = lo_q;
      else                         lo_d = lo_q + LO_W'(1);
    end
    hi_hit = sync_in & (hi_d == HI_W'(HI_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      sync_q <= sync_in;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign hi_cnt = hi_q;
  assign lo_cnt = lo_q;

  // R11
  hi_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q <= HI_W'(HI_MAX));

  // R11
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q == HI_W'(HI_MAX)) && sync_in |=> hi_q == HI_W'(HI_MAX));

endmodule

// File: rtl/pixsync_period_chk.sv
module pixsync_period_chk
  import pixsync_pkg::*;
#(
  parameter int unsigned PER_A = 12,
  parameter int unsigned PER_B = 16,
  parameter int unsigned HI_W  = 7,
  parameter int unsigned LO_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ratio_e          ratio,
  input  logic            rise_e,
  input  logic            sample_now,
  input  logic            pd_q,
  input  logic [HI_W-1:0] hi_cnt,
  input  logic [LO_W-1:0] lo_cnt,
  output logic            restart_now
);

  localparam logic [LO_W-1:0] NEED_A = LO_W'(low_span(PER_A));
  localparam logic [LO_W-1:0] NEED_B = LO_W'(low_span(PER_B));

  logic            synced_q, synced_d;
  logic            early_q, early_d;
  logic [LO_W-1:0] need;

  always_comb begin
    need     = (ratio == RATIO_16) ? NEED_B : NEED_A;
    synced_d = synced_q;
    early_d  = early_q;
    if (pd_q)            synced_d = 1'b0;
    else if (sample_now) synced_d = 1'b1;
    if (rise_e)          early_d = synced_q & (lo_cnt < need);
    else if (sample_now || pd_q) early_d = 1'b0;
    restart_now = early_q | (hi_cnt > HI_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      early_q  <= 1'b0;
    end else begin
      synced_q <= synced_d;
      early_q  <= early_d;
    end
  end

  // R7
  first_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_q && rise_e |=> !early_q);

endmodule

// File: rtl/pixsync_pd_ctrl.sv
module pixsync_pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic hi_hit,
  output logic pd_q
);

  logic pd_d;

  always_comb begin
    if (pd_q) pd_d = sync_in;
    else      pd_d = hi_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= pd_d;
  end

  // R10
  wake_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> !$past(sync_in));

  // R9
  enter_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(sync_in));

endmodule

// File: rtl/pixsync_seq.sv
module pixsync_seq
  import pixsync_pkg::*;
#(
  parameter int unsigned PER_A    = 12,
  parameter int unsigned PER_B    = 16,
  parameter int unsigned PD_EDGES = 64,
  parameter int unsigned IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ratio_sel,
  input  logic             pix_sync,
  output logic             sample_stb,
  output logic             conv_start,
  output logic [IDX_W-1:0] pix_idx,
  output logic             seq_restart,
  output logic             pwr_down,
  output logic             dout_oe
);

  localparam int unsigned HI_W = $clog2(PD_EDGES + 1);
  localparam int unsigned LO_W = $clog2(PER_B + 1);

  logic            rst_n_s;
  logic            rise_e, fall_e, hi_hit, pd_q;
  logic [HI_W-1:0] hi_cnt;
  logic [LO_W-1:0] lo_cnt;
  logic            sample_now, restart_now;
  ratio_e          ratio;

  logic             stb_q, conv_q, rs_q;
  logic             stb_d, conv_d, rs_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  pixsync_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  pixsync_edge_trk #(
    .HI_MAX (PD_EDGES),
    .LO_MAX (PER_B),
    .HI_W   (HI_W),
    .LO_W   (LO_W)
  ) u_trk (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sync_in (pix_sync),
    .rise_e  (rise_e),
    .fall_e  (fall_e),
    .hi_hit  (hi_hit),
    .hi_cnt  (hi_cnt),
    .lo_cnt  (lo_cnt)
  );

  pixsync_pd_ctrl u_pd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sync_in (pix_sync),
    .hi_hit  (hi_hit),
    .pd_q    (pd_q)
  );

  assign ratio      = ratio_e'(ratio_sel);
  assign sample_now = fall_e & ~pd_q;

  pixsync_period_chk #(
    .PER_A (PER_A),
    .PER_B (PER_B),
    .HI_W  (HI_W),
    .LO_W  (LO_W)
  ) u_per (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ratio       (ratio),
    .rise_e      (rise_e),
    .sample_now  (sample_now),
    .pd_q        (pd_q),
    .hi_cnt      (hi_cnt),
    .lo_cnt      (lo_cnt),
    .restart_now (restart_now)
  );

  always_comb begin
    stb_d  = sample_now;
    conv_d = stb_q;
    rs_d   = sample_now & restart_now;
    idx_d  = idx_q;
    if (hi_hit || pd_q)  idx_d = '0;
    else if (sample_now) idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      stb_q  <= 1'b0;
      conv_q <= 1'b0;
      rs_q   <= 1'b0;
      idx_q  <= '0;
    end else begin
      stb_q  <= stb_d;
      conv_q <= conv_d;
      rs_q   <= rs_d;
      idx_q  <= idx_d;
    end
  end

  assign sample_stb  = stb_q;
  assign conv_start  = conv_q;
  assign seq_restart = rs_q;
  assign pix_idx     = idx_q;
  assign pwr_down    = pd_q;
  assign dout_oe     = ~pd_q;

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sample_stb |=> !sample_stb);

  // R2
  stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sample_stb |-> !$past(pix_sync));

  // R3
  conv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sample_stb |=> conv_start);

  // R3
  conv_only_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    conv_start |-> $past(sample_stb));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sample_stb |-> pix_idx == $past(pix_idx) + IDX_W'(1));

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pwr_down |-> !sample_stb);

endmodule

// File: tb/pixsync_seq_tb_top.sv
module pixsync_seq_tb_top;

  localparam int IDX_W = 8;

  logic             clk;
  logic             rst_n;
  logic             ratio_sel;
  logic             pix_sync;
  logic             sample_stb;
  logic             conv_start;
  logic [IDX_W-1:0] pix_idx;
  logic             seq_restart;
  logic             pwr_down;
  logic             dout_oe;

  int tests_run = 0;
  int tests_bad = 0;
  bit done      = 0;

  typedef struct {
    bit               rs;
    logic [IDX_W-1:0] idx;
    string            tag;
  } exp_t;

  exp_t exp_q[$];

  // bench reference state
  bit               m_synced;
  int               m_prev_low;
  logic [IDX_W-1:0] m_idx;
  bit               mon_on;
  bit               prev_stb;

  pixsync_seq #(.IDX_W(IDX_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel   (ratio_sel),
    .pix_sync    (pix_sync),
    .sample_stb  (sample_stb),
    .conv_start  (conv_start),
    .pix_idx     (pix_idx),
    .seq_restart (seq_restart),
    .pwr_down    (pwr_down),
    .dout_oe     (dout_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    tests_run++;
    if (!ok) begin
      tests_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard when a strobe appears
  always @(negedge clk) begin
    if (mon_on && !done) begin
      chk(conv_start == prev_stb, "R3", "conv_start after strobe",
          int'(conv_start), int'(prev_stb));
      if (sample_stb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(seq_restart == e.rs, e.tag, "seq_restart", int'(seq_restart), int'(e.rs));
          chk(pix_idx == e.idx, "R4", "pix_idx", int'(pix_idx), int'(e.idx));
        end
      end
      prev_stb = sample_stb;
    end
  end

  // driver: one sync pulse of h high edges then l low edges
  task automatic pulse(input int h, input int l, input string tag);
    exp_t e;
    int   need;
    need = ratio_sel ? 15 : 11;
    e.rs  = (h > 1) || (m_synced && (m_prev_low < need));
    m_idx = m_idx + 1'b1;
    e.idx = m_idx;
    e.tag = tag;
    exp_q.push_back(e);
    m_synced   = 1'b1;
    m_prev_low = l;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      pix_sync = 1'b1;
    end
    for (int i = 0; i < l; i++) begin
      @(negedge clk);
      pix_sync = 1'b0;
    end
  endtask

  // driver: long high hold into power-down, then l low edges
  task automatic pd_hold(input int h, input int l);
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      if (i == 63) begin
        chk(pwr_down == 1'b0, "R9", "pwr_down after 63 edges", int'(pwr_down), 0);
      end
      if (i == 64) begin
        chk(pwr_down == 1'b1, "R9", "pwr_down after 64 edges", int'(pwr_down), 1);
        chk(dout_oe == 1'b0, "R9", "dout_oe in power-down", int'(dout_oe), 0);
        chk(pix_idx == 0, "R9", "pix_idx cleared", int'(pix_idx), 0);
      end
      pix_sync = 1'b1;
    end
    @(negedge clk);
    chk(pwr_down == 1'b1, "R11", "pwr_down held long", int'(pwr_down), 1);
    pix_sync = 1'b0;
    @(negedge clk);
    chk(pwr_down == 1'b0, "R10", "pwr_down after wake", int'(pwr_down), 0);
    chk(dout_oe == 1'b1, "R10", "dout_oe after wake", int'(dout_oe), 1);
    chk(pix_idx == 0, "R10", "pix_idx after wake", int'(pix_idx), 0);
    for (int i = 1; i < l; i++) @(negedge clk);
    m_synced = 1'b0;
    m_idx    = '0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      tests_run++;
      tests_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    ratio_sel  = 1'b0;
    pix_sync   = 1'b0;
    mon_on     = 1'b0;
    prev_stb   = 1'b0;
    m_synced   = 1'b0;
    m_prev_low = 0;
    m_idx      = '0;
    repeat (3) @(negedge clk);
    chk(sample_stb == 0, "R1", "sample_stb in reset", int'(sample_stb), 0);
    chk(pwr_down == 0, "R1", "pwr_down in reset", int'(pwr_down), 0);
    chk(dout_oe == 1, "R1", "dout_oe in reset", int'(dout_oe), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pix_idx == 0, "R1", "pix_idx after reset", int'(pix_idx), 0);
    chk(conv_start == 0, "R1", "conv_start after reset", int'(conv_start), 0);
    chk(seq_restart == 0, "R1", "seq_restart after reset", int'(seq_restart), 0);
    mon_on = 1'b1;

    // R5 nominal 12:1
    for (int k = 0; k < 6; k++) pulse(1, 11, "R5");
    // R7 short period, then one edge short
    pulse(1, 5, "R7");
    pulse(1, 11, "R7");
    pulse(1, 10, "R7");
    pulse(1, 11, "R7");
    // R8 widened pulses
    pulse(3, 11, "R8");
    pulse(1, 11, "R8");
    pulse(63, 11, "R8");
    chk(pwr_down == 0, "R9", "no power-down at 63", int'(pwr_down), 0);
    pulse(1, 11, "R5");

    // R6 16:1
    ratio_sel = 1'b1;
    pulse(1, 15, "R6");
    for (int k = 0; k < 3; k++) pulse(1, 15, "R6");
    pulse(1, 11, "R6");
    pulse(1, 14, "R6");
    pulse(1, 15, "R6");
    pulse(1, 15, "R6");

    // R9 / R10 / R11 power-down and wake
    pd_hold(100, 3);
    pulse(1, 3, "R10");
    pulse(1, 15, "R10");
    pulse(1, 15, "R6");

    // R4 wrap in 12:1
    ratio_sel = 1'b0;
    for (int k = 0; k < 260; k++) pulse(1, 11, "R4");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "strobes missing", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
    $finish;
  end

endmodule